// File: doc/BRIEF.md
# Driver Enable and Thermal Supervisor

This block sits between the supply and pin monitors of a power-stage gate driver and its gate sequencer. It takes an undervoltage-OK flag, the decoded state of the external disable pin and an unsigned die-temperature code in degrees Celsius. From these it produces the single enable that lets the sequencer switch, an active-low thermal warning flag, and a flag that marks a calibration interval in progress.

Turning the driver off never waits for a clock edge. Enabling waits for the pin to be seen high at a clock edge, and then for a fixed calibration interval. That interval starts again each time the pin rises. Two registered comparators with hysteresis track the die temperature. The lower one only raises the warning. The upper one forces the driver off until the die has cooled past its release point.

Top module: `drv_supervisor`

## Requirements
- R1: While `uv_ok_i` is 0, `drive_en_o` is 0 in the same cycle, whatever the pin and temperature inputs are.
- R2: Pin encoding on `dis_pin_i`: 2'b00 driven low, 2'b01 driven high, 2'b10 open (floating), 2'b11 invalid. Only 2'b01 allows enabling. When the pin leaves 2'b01, `drive_en_o` drops to 0 in the same cycle, with no clock edge involved.
- R3: A clock edge that samples the pin at 2'b01 after it was anything else starts calibration. `calib_busy_o` is then 1 for exactly CAL_CYCLES clock cycles (default 20), starting after that edge. `drive_en_o` stays 0 throughout and goes to 1 in the first cycle after `calib_busy_o` falls, provided the other conditions hold.
- R4: If the pin leaves 2'b01 during calibration, the interval is aborted and `calib_busy_o` goes to 0. The next rising edge of the pin starts a full new interval.
- R5: `thermal_warn_no` goes to 0 after the first clock edge that samples `temp_i` >= WARN_SET (default 150).
- R6: `thermal_warn_no` returns to 1 only after an edge that samples `temp_i` <= WARN_SET - WARN_HYS (default 135). For codes between the two points it keeps its value.
- R7: An active warning without shutdown leaves `drive_en_o` unchanged.
- R8: After an edge that samples `temp_i` >= SHUT_SET (default 180), `drive_en_o` is 0. It stays 0 until an edge samples `temp_i` <= SHUT_SET - SHUT_HYS (default 155).
- R9: A return of `uv_ok_i` to 1, or the end of thermal shutdown, brings `drive_en_o` back to 1 without a calibration interval.
- R10: While `rst_ni` is low, `drive_en_o` is 0, `thermal_warn_no` is 1 and `calib_busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_ok_i | input | 1 | Supply above undervoltage threshold |
| dis_pin_i | input | 2 | Decoded disable-pin state (00 low, 01 high, 10 open) |
| temp_i | input | TEMP_W | Die temperature code in °C, unsigned |
| drive_en_o | output | 1 | Gate sequencer may switch |
| thermal_warn_no | output | 1 | Thermal warning, active low |
| calib_busy_o | output | 1 | Zero-cross threshold calibration in progress |

## Verification
A wrong warning or shutdown register shows up at `thermal_warn_no` or `drive_en_o` one edge after the offending temperature code. It is most visible when the code sits inside a hysteresis band, because there a correct design must hold its previous value. A stale edge detector or a wrong calibration counter changes the length of the `calib_busy_o` pulse, or lets `drive_en_o` rise early. Both are seen within CAL_CYCLES + 1 cycles of a pin rising edge. Missing combinational gating of the pin or the supply flag is seen in the very cycle the input changes.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
  typedef enum logic [1:0] {
    PIN_LOW  = 2'b00,
    PIN_HIGH = 2'b01,
    PIN_OPEN = 2'b10,
    PIN_BAD  = 2'b11
  } pin_state_e;
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int W   = 8,
  parameter int SET = 150,
  parameter int HYS = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  output logic         flag_o
);
  localparam logic [W-1:0] SetV = W'(SET);
  localparam logic [W-1:0] ClrV = W'(SET - HYS);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (val_i >= SetV)   flag_q <= 1'b1;
    else if (val_i <= ClrV)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/calib_timer.sv
module calib_timer #(
  parameter int LEN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LenV = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (abort_i)       cnt_q <= '0;
    else if (start_i)       cnt_q <= LenV;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor
  import drv_sup_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int WARN_SET   = 150,
  parameter int WARN_HYS   = 15,
  parameter int SHUT_SET   = 180,
  parameter int SHUT_HYS   = 25,
  parameter int CAL_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uv_ok_i,
  input  logic [1:0]        dis_pin_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              drive_en_o,
  output logic              thermal_warn_no,
  output logic              calib_busy_o
);
  logic pin_high, pin_high_q, cal_start;
  logic warn, shut, busy;

  assign pin_high  = (dis_pin_i == PIN_HIGH);
  assign cal_start = pin_high & ~pin_high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_high_q <= 1'b0;
    else         pin_high_q <= pin_high;
  end

  hyst_cmp #(.W(TEMP_W), .SET(WARN_SET), .HYS(WARN_HYS)) u_warn (
    .clk_i (clk_i), .rst_ni(rst_ni), .val_i(temp_i), .flag_o(warn)
  );

  hyst_cmp #(.W(TEMP_W), .SET(SHUT_SET), .HYS(SHUT_HYS)) u_shut (
    .clk_i (clk_i), .rst_ni(rst_ni), .val_i(temp_i), .flag_o(shut)
  );

  calib_timer #(.LEN(CAL_CYCLES)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cal_start),
    .abort_i(~pin_high),
    .busy_o (busy)
  );

  // disable paths are combinational; enable needs the registered pin view
  assign drive_en_o      = uv_ok_i & pin_high & pin_high_q & ~busy & ~shut;
  assign thermal_warn_no = ~warn;
  assign calib_busy_o    = busy;
endmodule

// File: rtl/drv_supervisor_chk.sv
module drv_supervisor_chk #(
  parameter int TEMP_W     = 8,
  parameter int WARN_SET   = 150,
  parameter int WARN_HYS   = 15,
  parameter int SHUT_SET   = 180,
  parameter int SHUT_HYS   = 25,
  parameter int CAL_CYCLES = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              uv_ok_i,
  input logic [1:0]        dis_pin_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic              drive_en_o,
  input logic              thermal_warn_no,
  input logic              calib_busy_o
);
  localparam logic [TEMP_W-1:0] WSet = TEMP_W'(WARN_SET);
  localparam logic [TEMP_W-1:0] WClr = TEMP_W'(WARN_SET - WARN_HYS);
  localparam logic [TEMP_W-1:0] SSet = TEMP_W'(SHUT_SET);

  logic pin_hi;
  assign pin_hi = (dis_pin_i == 2'b01);

  // R1
  uv_blocks_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_ok_i |-> !drive_en_o);

  // R2
  pin_blocks_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_hi |-> !drive_en_o);

  // R3
  calib_blocks_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calib_busy_o |-> !drive_en_o);

  // R3
  pin_rise_calib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_hi) |=> calib_busy_o);

  // R5
  warn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= WSet) |=> !thermal_warn_no);

  // R6
  warn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i > WClr && temp_i < WSet) |=> $stable(thermal_warn_no));

  // R8
  shut_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= SSet) |=> !drive_en_o);
endmodule

bind drv_supervisor drv_supervisor_chk #(
  .TEMP_W(TEMP_W), .WARN_SET(WARN_SET), .WARN_HYS(WARN_HYS),
  .SHUT_SET(SHUT_SET), .SHUT_HYS(SHUT_HYS), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uv_ok_i(uv_ok_i), .dis_pin_i(dis_pin_i),
  .temp_i(temp_i), .drive_en_o(drive_en_o), .thermal_warn_no(thermal_warn_no),
  .calib_busy_o(calib_busy_o)
);

// File: tb/drv_supervisor_tb.sv
module drv_supervisor_tb;
  localparam int ClkPeriod = 10;
  localparam int Cal = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uv_ok = 1'b0;
  logic [1:0] pin = 2'b00;
  logic [7:0] temp = 8'd25;
  logic       drive_en, warn_n, busy;
  int         n_chk = 0, n_fail = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  drv_supervisor #(.CAL_CYCLES(Cal)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uv_ok_i(uv_ok), .dis_pin_i(pin),
    .temp_i(temp), .drive_en_o(drive_en), .thermal_warn_no(warn_n),
    .calib_busy_o(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count busy cycles seen at successive negedges after a pin rise
  task automatic count_busy(input string req);
    int cnt = 0;
    bit early = 0;
    for (int i = 0; i < Cal + 5; i++) begin
      step(1);
      if (busy) begin
        cnt++;
        if (drive_en) early = 1;
      end else break;
    end
    n_chk++;
    if (cnt != Cal) begin
      n_fail++;
      $display("FAIL %s: busy length %0d expected %0d", req, cnt, Cal);
    end
    chk({req, " drive low during calib"}, early, 1'b0);
    chk({req, " drive after calib"}, drive_en, 1'b1);
  endtask

  task automatic t_reset();
    #1;
    chk("R10 drive", drive_en, 1'b0);
    chk("R10 warn_n", warn_n, 1'b1);
    chk("R10 busy", busy, 1'b0);
    step(1);
    rst_n = 1'b1;
    uv_ok = 1'b1;
    step(2);
  endtask

  task automatic t_enable();
    pin = 2'b01;
    #1;
    chk("R3 drive before edge", drive_en, 1'b0);
    count_busy("R3");
  endtask

  task automatic t_pin_states();
    pin = 2'b10; #1; chk("R2 open", drive_en, 1'b0);
    step(2);     chk("R2 open held", drive_en, 1'b0);
    pin = 2'b11; #1; chk("R2 invalid", drive_en, 1'b0);
    pin = 2'b00; #1; chk("R2 low", drive_en, 1'b0);
    step(1);
    pin = 2'b01;
    count_busy("R3 re-enable");
  endtask

  task automatic t_abort();
    pin = 2'b00; step(1);
    pin = 2'b01; step(4);
    chk("R4 busy mid", busy, 1'b1);
    pin = 2'b10; step(1);
    chk("R4 aborted", busy, 1'b0);
    pin = 2'b01;
    count_busy("R4 restart");
  endtask

  task automatic t_uv();
    uv_ok = 1'b0; #1; chk("R1 uv low", drive_en, 1'b0);
    step(3);          chk("R1 uv held", drive_en, 1'b0);
    uv_ok = 1'b1; #1;
    chk("R9 uv return", drive_en, 1'b1);
    step(1);
    chk("R9 no calib on uv", busy, 1'b0);
  endtask

  task automatic t_warn();
    temp = 8'd149; step(1); chk("R5 below", warn_n, 1'b1);
    temp = 8'd150; step(1); chk("R5 set", warn_n, 1'b0);
    chk("R7 drive kept", drive_en, 1'b1);
    temp = 8'd140; step(1); chk("R6 hold", warn_n, 1'b0);
    temp = 8'd136; step(1); chk("R6 hold edge", warn_n, 1'b0);
    temp = 8'd135; step(1); chk("R6 clear", warn_n, 1'b1);
    temp = 8'd149; step(1); chk("R6 hold off", warn_n, 1'b1);
  endtask

  task automatic t_shut();
    temp = 8'd179; step(1); chk("R8 below", drive_en, 1'b1);
    temp = 8'd180; step(1); chk("R8 shut", drive_en, 1'b0);
    chk("R8 warn too", warn_n, 1'b0);
    temp = 8'd160; step(1); chk("R8 hold", drive_en, 1'b0);
    temp = 8'd156; step(1); chk("R8 hold edge", drive_en, 1'b0);
    temp = 8'd155; step(1); chk("R9 shut exit", drive_en, 1'b1);
    chk("R9 no calib on exit", busy, 1'b0);
    chk("R6 warn kept", warn_n, 1'b0);
    temp = 8'd25; step(1); chk("R6 cool", warn_n, 1'b1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(1);
    t_reset();
    t_enable();
    t_pin_states();
    t_abort();
    t_uv();
    t_warn();
    t_shut();
    finish_run();
  end
endmodule